// File: doc/BRIEF.md
# Bus-Matching Read Unpacker

This block sits between a storage queue that always delivers 36-bit long words and a read port whose width can be set to a long word, a word or a byte. The 36-bit output register is split into four 9-bit byte lanes: bits 8:0, 17:9, 26:18 and 35:27. In long-word mode, every read takes one long word from the queue and places all of it on the output.

In word or byte mode, the block takes one long word from the queue and presents its first piece on the low lanes. It keeps the whole word in a hold register and serves the other pieces on later reads, without taking more from the queue. An endian select sets the order of the pieces. It is sampled when a word is taken, and that value applies to every piece of that word.

Changing the width between reads throws away any pieces not yet read and takes a fresh word. In narrow modes, the output bits above the active lanes keep their last value.

Top module: `bus_match_unpacker`

## Requirements
- R1: The block has a synchronous active-high reset. After reset, the output register is zero, no pieces are held, and the recorded width is long word.
- R2: In long-word mode (`bus_size` 00), a read with `fifo_empty` low asserts `fifo_pop` in that cycle. At the clock edge, all 36 bits of `fifo_data` are loaded into `dout`.
- R3: In word mode (`bus_size` 01), a read with nothing held pops one long word and loads the first 18-bit half into `dout[17:0]`. The next word-mode read loads the other half without popping.
- R4: In byte mode (`bus_size` 10), a read with nothing held pops one long word and loads the first 9-bit lane into `dout[8:0]`. The next three byte-mode reads load the remaining lanes, one per read, without popping.
- R5: The endian bit is sampled when a word is popped. With `big_endian` at 0, pieces come out from least to most significant: lanes 0,1,2,3, or the low half then the high half. With `big_endian` at 1, the order is reversed.
- R6: A read whose width differs from the width of the previous read pops a new word when one is available. Any held pieces are discarded.
- R7: A byte-mode read leaves `dout[35:9]` unchanged. A word-mode read leaves `dout[35:18]` unchanged.
- R8: `fifo_pop` is never asserted while `fifo_empty` is high. A read that needs a new word while the queue is empty leaves `dout` unchanged. It still drops any held pieces and records the new width.
- R9: `bus_size` code 11 behaves exactly like long-word mode.
- R10: When `rd_en` is low, `fifo_pop` stays low and `dout` and the held state do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; all registers update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| rd_en | input | 1 | Read strobe from the narrow port |
| bus_size | input | 2 | Width select: 00 long word, 01 word, 10 byte, 11 long word |
| big_endian | input | 1 | Piece order: 0 = least significant first, 1 = most significant first |
| fifo_empty | input | 1 | High when the queue holds no long word |
| fifo_data | input | 36 | Head long word of the queue, valid while `fifo_empty` is low |
| fifo_pop | output | 1 | Removes the head word at the next rising edge |
| dout | output | 36 | Output register |

## Verification
The bench attacks the width-change path: it switches from byte to word after two bytes. A design that kept counting would return stale bytes from the old word and never pop the new one. It reads while the queue is empty, both with a width change and without one. A design that popped anyway would emit garbage, and a design that kept the held remainder after the width change would later resume an old word. It also checks the bits above the active lanes in every narrow read and runs both endian orders in each width, which catches lane swaps and overwritten upper lanes.

// File: rtl/bus_match_unpacker.sv
module bus_match_unpacker #(
  parameter int LANE_W = 9
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  rd_en,
  input  logic [1:0]            bus_size,
  input  logic                  big_endian,
  input  logic                  fifo_empty,
  input  logic [4*LANE_W-1:0]   fifo_data,
  output logic                  fifo_pop,
  output logic [4*LANE_W-1:0]   dout
);
  localparam int LW = 4 * LANE_W;
  localparam int HW = 2 * LANE_W;
  localparam logic [1:0] SZ_LONG = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b01;
  localparam logic [1:0] SZ_BYTE = 2'b10;

  logic [LW-1:0] hold_q;
  logic [1:0]    left_q;
  logic [1:0]    size_q;
  logic          be_q;

  logic [1:0] mode;
  logic       need_new;
  logic [LW-1:0] src;
  logic       src_be;
  logic [1:0] idx;
  logic [1:0] lane;
  logic       half;
  logic [LANE_W-1:0] byte_val;
  logic [HW-1:0]     word_val;

  assign mode     = (bus_size == 2'b11) ? SZ_LONG : bus_size;
  assign need_new = (mode != size_q) || (left_q == 2'd0);
  assign fifo_pop = rd_en && need_new && !fifo_empty;
  assign src      = fifo_pop ? fifo_data : hold_q;
  assign src_be   = fifo_pop ? big_endian : be_q;
  assign idx      = fifo_pop ? 2'd0 : ((mode == SZ_BYTE) ? (2'd0 - left_q) : 2'd1);
  assign lane     = src_be ? ~idx : idx;
  assign half     = src_be ? ~idx[0] : idx[0];

  always_comb begin
    case (lane)
      2'd0:    byte_val = src[LANE_W-1:0];
      2'd1:    byte_val = src[2*LANE_W-1:LANE_W];
      2'd2:    byte_val = src[3*LANE_W-1:2*LANE_W];
      default: byte_val = src[4*LANE_W-1:3*LANE_W];
    endcase
    word_val = half ? src[LW-1:HW] : src[HW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dout   <= '0;
      hold_q <= '0;
      left_q <= 2'd0;
      size_q <= SZ_LONG;
      be_q   <= 1'b0;
    end else if (rd_en) begin
      if (fifo_pop) begin
        hold_q <= fifo_data;
        be_q   <= big_endian;
        size_q <= mode;
        left_q <= (mode == SZ_BYTE) ? 2'd3 : (mode == SZ_WORD) ? 2'd1 : 2'd0;
      end else if (need_new) begin
        size_q <= mode;
        left_q <= 2'd0;
      end else begin
        left_q <= left_q - 2'd1;
      end
      if (fifo_pop || !need_new) begin
        case (mode)
          SZ_WORD: dout[HW-1:0]     <= word_val;
          SZ_BYTE: dout[LANE_W-1:0] <= byte_val;
          default: dout             <= src;
        endcase
      end
    end
  end

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> (dout == '0));

  p_long_load_r2: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_size == 2'b00 && !fifo_empty) |=> (dout == $past(fifo_data)));

  p_byte_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_size == 2'b10) |=> (dout[LW-1:LANE_W] == $past(dout[LW-1:LANE_W])));

  p_word_upper_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_size == 2'b01) |=> (dout[LW-1:HW] == $past(dout[LW-1:HW])));

  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !fifo_pop);

  p_code3_long_r9: assert property (@(posedge clk) disable iff (rst)
    (rd_en && bus_size == 2'b11 && !fifo_empty) |=> (dout == $past(fifo_data)));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> ($stable(dout) && !$past(fifo_pop)));
endmodule

// File: tb/bus_match_unpacker_test.sv
`timescale 1ns/1ps
module bus_match_unpacker_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_en = 1'b0;
  logic [1:0] bus_size = 2'b00;
  logic big_endian = 1'b0;
  logic fifo_empty;
  logic [35:0] fifo_data;
  logic fifo_pop;
  logic [35:0] dout;

  bus_match_unpacker #(.LANE_W(9)) uut (
    .clk(clk), .rst(rst), .rd_en(rd_en), .bus_size(bus_size),
    .big_endian(big_endian), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .fifo_pop(fifo_pop), .dout(dout)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [35:0] q[$];
  logic [35:0] pend[$];
  int last_sz = 0;
  logic [35:0] exp_dout = '0;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic refresh();
    fifo_empty = (q.size() == 0);
    fifo_data  = (q.size() == 0) ? 36'h0 : q[0];
  endtask

  task automatic check(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit rd, input bit [1:0] sz, input bit be);
    int m;
    bit exp_pop;
    string tag;
    logic [35:0] w;
    logic [35:0] p;
    logic [35:0] prev;
    rd_en = rd; bus_size = sz; big_endian = be;
    refresh();
    #1;
    m = (sz == 2'b11) ? 0 : int'(sz);
    exp_pop = 0;
    prev = dout;
    tag = (sz == 2'b11) ? "R9" : (m == 0) ? "R2" : (m == 1) ? "R3" : "R4";
    if (!rd) tag = "R10";
    else if (m != last_sz || pend.size() == 0) begin
      if (m != last_sz) tag = "R6";
      if (q.size() == 0) begin
        tag = "R8";
        pend.delete();
        last_sz = m;
      end else begin
        exp_pop = 1;
        w = q[0];
        pend.delete();
        if (m == 0) pend.push_back(w);
        else if (m == 1) begin
          if (be) begin pend.push_back({18'h0, w[35:18]}); pend.push_back({18'h0, w[17:0]}); end
          else    begin pend.push_back({18'h0, w[17:0]});  pend.push_back({18'h0, w[35:18]}); end
        end else begin
          for (int k = 0; k < 4; k++) begin
            int ln;
            ln = be ? 3 - k : k;
            pend.push_back({27'h0, w[ln*9 +: 9]});
          end
        end
        last_sz = m;
      end
    end
    if (rd && m != 0 && be && tag != "R8") tag = "R5";
    if (rd && (exp_pop || (tag != "R8" && pend.size() > 0 && !(m == 0)))) begin
      p = pend.pop_front();
      if (m == 0) exp_dout = p;
      else if (m == 1) exp_dout[17:0] = p[17:0];
      else exp_dout[8:0] = p[8:0];
    end
    check(fifo_pop == exp_pop, exp_pop ? tag : (q.size() == 0 ? "R8" : tag),
          {35'h0, fifo_pop}, {35'h0, exp_pop});
    @(posedge clk);
    #1;
    if (exp_pop) void'(q.pop_front());
    refresh();
    @(negedge clk);
    check(dout == exp_dout, tag, dout, exp_dout);
    if (rd && m == 2) check(dout[35:9] == prev[35:9], "R7", dout, prev);
    if (rd && m == 1) check(dout[35:18] == prev[35:18], "R7", dout, prev);
  endtask

  initial begin
    refresh();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(dout == 36'h0, "R1", dout, 36'h0);
    check(fifo_pop == 1'b0, "R1", {35'h0, fifo_pop}, 36'h0);

    q.push_back(36'h123456789); q.push_back(36'hFEDCBA987);
    cyc(1, 2'b00, 0); cyc(1, 2'b00, 0);
    cyc(1, 2'b00, 0);
    q.push_back(36'hA5A5A5A5A);
    cyc(1, 2'b01, 0); cyc(1, 2'b01, 0);
    q.push_back(36'h3C3C3C3C3);
    cyc(1, 2'b01, 1); cyc(1, 2'b01, 1);
    q.push_back(36'h1FF0AB3C5);
    for (int i = 0; i < 4; i++) cyc(1, 2'b10, 0);
    q.push_back(36'h80402010F);
    for (int i = 0; i < 4; i++) cyc(1, 2'b10, 1);
    q.push_back(36'h111222333); q.push_back(36'h444555666);
    cyc(1, 2'b10, 0); cyc(1, 2'b10, 0);
    cyc(1, 2'b01, 0); cyc(1, 2'b01, 0);
    q.push_back(36'hDEADBEEF1);
    cyc(1, 2'b11, 0); cyc(1, 2'b00, 0);
    q.push_back(36'h0F0F0F0F0);
    cyc(1, 2'b10, 0);
    cyc(1, 2'b01, 0); cyc(1, 2'b10, 0);
    q.push_back(36'h987654321);
    cyc(1, 2'b10, 0); cyc(1, 2'b10, 0);
    cyc(0, 2'b00, 0); cyc(0, 2'b01, 1); cyc(0, 2'b10, 0);

    for (int i = 0; i < 600; i++) begin
      if (q.size() < 4 && ($urandom % 3) == 0)
        q.push_back({$urandom, $urandom}[35:0]);
      cyc(($urandom % 10) < 7, 2'($urandom % 4), 1'($urandom % 2));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule